// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address Wake-Up

This block receives asynchronous serial characters. A tick input at sixteen times the bit rate paces it. The serial input is taken either from the line pin or, in loopback, from the local transmitter's output. The selected input is synchronised, a start bit is qualified, and a character of 5 to 8 data bits is rebuilt, least significant bit first. An optional parity bit and one stop bit follow the data bits. Each completed character moves into a one-deep buffer. The buffer holds the character, its parity, framing and break flags, and a search-hit flag. A new character can be received while the buffered one waits to be read.

For multi-drop links the block has a wake-up mode. Each frame then carries an address flag bit. Frames with the flag set are addresses. They are compared in hardware against a programmed station address and never reach the buffer. Data frames are delivered only after a matching address. An optional search compare marks any delivered character that equals a programmed value.

Top module: `async_rx_wake`

## Requirements
- R1: The input is examined only on cycles with `tick16` high. A low level seen while idle arms a start. The start is confirmed only if the input is still low on the 8th tick after that one; otherwise it is dropped and no character results. Each data bit is then sampled every 16 ticks, least significant bit first.
- R2: `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits of `rx_data` above the word length read 0.
- R3: `par_mode` 1 selects even parity and 2 selects odd parity. Codes 0 and 3 select no parity bit. The parity bit follows the data bits, or follows the address flag when there is one, and covers the data bits only. `par_err` is set when the received parity bit disagrees with the selected parity. It is never set when there is no parity.
- R4: `frm_err` is set for a character whose stop bit is sampled low.
- R5: A frame whose data bits, address flag, parity bit and stop bit are all zero is a break. It is delivered with `brk_det`=1, `frm_err`=1 and `rx_data`=0, even while wake-up mode is asleep.
- R6: When a character is delivered, `rx_ready` rises and the data and its flags are held until `rd_ack` is pulsed. `rd_ack` clears `rx_ready` and `ovr_err`.
- R7: A character that completes while `rx_ready`=1, with no `rd_ack` in the same cycle, sets `ovr_err`. The buffered character and its flags are kept.
- R8: With `wake_en`=1, an address flag bit follows the data bits. A frame with the flag set to 1 is never delivered. Its data sets `addr_match` to 1 if it equals `own_addr` and to 0 if it does not. Frames with the flag at 0 are delivered only while `addr_match`=1. With `wake_en`=0 there is no flag bit, `addr_match` is 0 and every character is delivered.
- R9: `char_hit` is 1 for a delivered character when `search_en`=1 and the data equals `search_char`, and 0 otherwise.
- R10: With `loop_en`=1 the receiver takes `tx_loop` as its input, and `rx_line` has no effect.
- R11: After reset, `rx_ready`, `par_err`, `frm_err`, `ovr_err`, `brk_det`, `char_hit` and `addr_match` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rx_line | input | 1 | Serial input from the line |
| tx_loop | input | 1 | Local transmitter output, used in loopback |
| loop_en | input | 1 | Select `tx_loop` as the receive input |
| word_len | input | 2 | Data bits: code + 5 |
| par_mode | input | 2 | 0/3 none, 1 even, 2 odd |
| wake_en | input | 1 | Address wake-up mode |
| own_addr | input | 8 | Station address for wake-up |
| search_en | input | 1 | Enable character search |
| search_char | input | 8 | Character searched for |
| rd_ack | input | 1 | Buffered character has been read |
| rx_data | output | 8 | Buffered character |
| rx_ready | output | 1 | Buffer holds an unread character |
| par_err | output | 1 | Parity error of the buffered character |
| frm_err | output | 1 | Framing error of the buffered character |
| ovr_err | output | 1 | A character was lost while the buffer was full |
| brk_det | output | 1 | Buffered character is a break |
| addr_match | output | 1 | Station is addressed (awake) |
| char_hit | output | 1 | Buffered character matched the search value |

## Verification
A wrong bit counter or sample phase shows up within one frame. The character is shifted or truncated in `rx_data`, or a parity or framing flag appears on a clean frame. A stuck sleep/awake state appears at the ports as characters that are delivered or withheld wrongly. This shows on the first data frame after an address frame, with `addr_match` giving the cause directly. A buffer that fails to hold shows as a changed `rx_data` or a missing `ovr_err` after the second unacknowledged frame.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned WORD_MAX = 8;
    localparam int unsigned BIT_W    = $clog2(WORD_MAX);

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_ODD   = 2'd2,
        PAR_NONE2 = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_FLAG,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [WORD_MAX-1:0] data;
        logic                par_err;
        logic                frm_err;
        logic                brk;
        logic                is_addr;
    } rx_frame_t;

    // number of data bits for a length code
    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic par_on(input logic [1:0] mode);
        return (mode == PAR_EVEN) || (mode == PAR_ODD);
    endfunction

    // parity bit a correct sender transmits for these data bits
    function automatic logic par_expect(input logic [1:0] mode,
                                        input logic [WORD_MAX-1:0] d);
        return (mode == PAR_ODD) ? ~(^d) : (^d);
    endfunction

endpackage

// File: rtl/srx_front.sv
module srx_front #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic loop_en,
    input  logic rx_line,
    input  logic tx_loop,
    output logic line_s
);
    logic                   src;
    logic [SYNC_STAGES-1:0] chain;

    assign src = loop_en ? tx_loop : rx_line;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= src;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], src};
            end
        end
    endgenerate

    assign line_s = chain[SYNC_STAGES-1];

endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
    import srx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line,
    input  logic [1:0] word_len,
    input  logic [1:0] par_mode,
    input  logic       wake_en,
    output logic       done,
    output rx_frame_t  frame
);
    localparam int unsigned CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(OSR - 1);

    rx_state_e           state;
    logic [CNT_W-1:0]    cnt;
    logic [BIT_W-1:0]    bitn;
    logic [WORD_MAX-1:0] shreg;
    logic                flagb;
    logic                parb;
    logic                allz;
    logic                last_bit;
    rx_state_e           after_data;
    rx_state_e           after_flag;

    assign last_bit   = ({1'b0, bitn} == (word_bits(word_len) - 4'd1));
    assign after_flag = par_on(par_mode) ? ST_PAR : ST_STOP;
    assign after_data = wake_en ? ST_FLAG : after_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            flagb <= 1'b0;
            parb  <= 1'b0;
            allz  <= 1'b0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (!line) begin
                            state <= ST_START;
                            cnt   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt == HALF) begin
                            cnt <= '0;
                            if (!line) begin
                                state <= ST_DATA;
                                bitn  <= '0;
                                shreg <= '0;
                                allz  <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL) begin
                            cnt         <= '0;
                            shreg[bitn] <= line;
                            allz        <= allz & ~line;
                            if (last_bit) state <= after_data;
                            else          bitn  <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_FLAG: begin
                        if (cnt == FULL) begin
                            cnt   <= '0;
                            flagb <= line;
                            allz  <= allz & ~line;
                            state <= after_flag;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt == FULL) begin
                            cnt   <= '0;
                            parb  <= line;
                            allz  <= allz & ~line;
                            state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == FULL) begin
                            cnt           <= '0;
                            done          <= 1'b1;
                            frame.data    <= shreg;
                            frame.par_err <= par_on(par_mode) &&
                                             (parb != par_expect(par_mode, shreg));
                            frame.frm_err <= ~line;
                            frame.brk     <= allz & ~line;
                            frame.is_addr <= wake_en & flagb;
                            state         <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // data phase is only entered from a start that was still low
    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_START) |-> !$past(line)); // R1
    AST_DONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1
    AST_BRK_FRAMING: assert property (@(posedge clk) disable iff (rst)
        (done && frame.brk) |-> frame.frm_err); // R5
    AST_NO_PAR_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (done && !par_on($past(par_mode))) |-> !frame.par_err); // R3

endmodule

// File: rtl/srx_filter.sv
module srx_filter
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_done,
    input  rx_frame_t           in_frame,
    input  logic                wake_en,
    input  logic [WORD_MAX-1:0] own_addr,
    input  logic                search_en,
    input  logic [WORD_MAX-1:0] search_char,
    input  logic                rd_ack,
    output logic [WORD_MAX-1:0] buf_data,
    output logic                rx_ready,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                brk_det,
    output logic                addr_match,
    output logic                char_hit
);
    logic awake;
    logic is_addr_frame;
    logic deliver;

    assign is_addr_frame = in_done && wake_en && in_frame.is_addr && !in_frame.brk;
    assign deliver = in_done &&
                     (in_frame.brk || !wake_en || (!in_frame.is_addr && awake));

    always_ff @(posedge clk) begin
        if (rst) begin
            awake <= 1'b0;
        end else if (!wake_en) begin
            awake <= 1'b0;
        end else if (is_addr_frame) begin
            awake <= (in_frame.data == own_addr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_data <= '0;
            rx_ready <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            ovr_err  <= 1'b0;
            brk_det  <= 1'b0;
            char_hit <= 1'b0;
        end else if (deliver && rx_ready && !rd_ack) begin
            ovr_err <= 1'b1;
        end else if (deliver) begin
            buf_data <= in_frame.data;
            par_err  <= in_frame.par_err;
            frm_err  <= in_frame.frm_err;
            brk_det  <= in_frame.brk;
            char_hit <= search_en && (in_frame.data == search_char);
            rx_ready <= 1'b1;
            ovr_err  <= 1'b0;
        end else if (rd_ack) begin
            rx_ready <= 1'b0;
            ovr_err  <= 1'b0;
        end
    end

    assign addr_match = awake;

    AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && !rd_ack) |=> (rx_ready && $stable(buf_data))); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !in_done) |=> (!rx_ready && !ovr_err)); // R6
    AST_ASLEEP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (in_done && wake_en && !awake && !in_frame.brk && !rd_ack)
        |=> $stable(rx_ready)); // R8
    AST_ADDR_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (is_addr_frame && !rx_ready) |=> !rx_ready); // R8
    AST_ASLEEP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !wake_en |=> !addr_match); // R8

endmodule

// File: rtl/async_rx_wake.sv
module async_rx_wake
    import srx_pkg::*;
#(
    parameter int unsigned OSR         = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick16,
    input  logic                rx_line,
    input  logic                tx_loop,
    input  logic                loop_en,
    input  logic [1:0]          word_len,
    input  logic [1:0]          par_mode,
    input  logic                wake_en,
    input  logic [WORD_MAX-1:0] own_addr,
    input  logic                search_en,
    input  logic [WORD_MAX-1:0] search_char,
    input  logic                rd_ack,
    output logic [WORD_MAX-1:0] rx_data,
    output logic                rx_ready,
    output logic                par_err,
    output logic                frm_err,
    output logic                ovr_err,
    output logic                brk_det,
    output logic                addr_match,
    output logic                char_hit
);
    logic      line_s;
    logic      fr_done;
    rx_frame_t fr;

    srx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk     (clk),
        .rst     (rst),
        .loop_en (loop_en),
        .rx_line (rx_line),
        .tx_loop (tx_loop),
        .line_s  (line_s)
    );

    srx_deframer #(.OSR(OSR)) u_deframe (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick16),
        .line     (line_s),
        .word_len (word_len),
        .par_mode (par_mode),
        .wake_en  (wake_en),
        .done     (fr_done),
        .frame    (fr)
    );

    srx_filter u_filter (
        .clk         (clk),
        .rst         (rst),
        .in_done     (fr_done),
        .in_frame    (fr),
        .wake_en     (wake_en),
        .own_addr    (own_addr),
        .search_en   (search_en),
        .search_char (search_char),
        .rd_ack      (rd_ack),
        .buf_data    (rx_data),
        .rx_ready    (rx_ready),
        .par_err     (par_err),
        .frm_err     (frm_err),
        .ovr_err     (ovr_err),
        .brk_det     (brk_det),
        .addr_match  (addr_match),
        .char_hit    (char_hit)
    );

endmodule

// File: tb/tb_async_rx_wake.sv
`timescale 1ns/1ps
module tb_async_rx_wake;

    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic       tx_loop = 1'b1;
    logic       loop_en = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic [1:0] par_mode = 2'd0;
    logic       wake_en = 1'b0;
    logic [7:0] own_addr = 8'h00;
    logic       search_en = 1'b0;
    logic [7:0] search_char = 8'h00;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, par_err, frm_err, ovr_err, brk_det, addr_match, char_hit;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    async_rx_wake dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_line), .tx_loop(tx_loop),
        .loop_en(loop_en), .word_len(word_len), .par_mode(par_mode), .wake_en(wake_en),
        .own_addr(own_addr), .search_en(search_en), .search_char(search_char),
        .rd_ack(rd_ack), .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err), .brk_det(brk_det),
        .addr_match(addr_match), .char_hit(char_hit)
    );

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            div    = (div + 1) % TICK_DIV;
            tick16 = (div == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_bit(input logic b, input bit via_loop);
        if (via_loop) tx_loop = b;
        else          rx_line = b;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // start, data LSB first, [flag], [parity], stop, one idle bit
    task automatic send(input logic [7:0] d, input int nb, input int pm,
                        input bit flag, input bit stopv, input bit badpar, input bit via_loop);
        logic [7:0] m;
        logic       p;
        m = d & ((8'd1 << nb) - 8'd1);
        p = (pm == 2) ? ~(^m) : (^m);
        if (badpar) p = ~p;
        put_bit(1'b0, via_loop);
        for (int i = 0; i < nb; i++) put_bit(m[i], via_loop);
        if (wake_en) put_bit(flag, via_loop);
        if (pm == 1 || pm == 2) put_bit(p, via_loop);
        put_bit(stopv, via_loop);
        put_bit(1'b1, via_loop);
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] vals [6];
        vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset outputs",
            {rx_ready, par_err, frm_err, ovr_err, brk_det, char_hit, addr_match}, 0);
        repeat (BIT_CLKS) @(negedge clk);

        // R2 / R3 sweep of length and parity
        for (int l = 0; l < 4; l++) begin
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [7:0] exp_d;
                    word_len = l[1:0];
                    par_mode = p[1:0];
                    exp_d = vals[k] & ((8'd1 << (l + 5)) - 8'd1);
                    send(vals[k], l + 5, p, 1'b0, 1'b1, 1'b0, 1'b0);
                    chk("R6 ready after frame", rx_ready, 1);
                    chk("R2 data width", rx_data, exp_d);
                    chk("R3 clean parity", par_err, 0);
                    chk("R4 clean stop", {frm_err, brk_det}, 0);
                    ack();
                    chk("R6 ack clears ready", rx_ready, 0);
                end
            end
        end

        // R3 parity errors, both senses, and the reserved code
        word_len = 2'd3;
        for (int p = 1; p < 3; p++) begin
            par_mode = p[1:0];
            send(8'h6B, 8, p, 1'b0, 1'b1, 1'b1, 1'b0);
            chk("R3 wrong parity flagged", {rx_ready, par_err}, 2'b11);
            chk("R3 data kept on parity error", rx_data, 8'h6B);
            ack();
        end
        par_mode = 2'd3;
        send(8'h6B, 8, 3, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R3 code 3 has no parity bit", {rx_ready, par_err, rx_data}, {2'b10, 8'h6B});
        ack();
        par_mode = 2'd0;

        // R4 framing error
        send(8'h55, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R4 low stop", {rx_ready, frm_err, brk_det}, 3'b110);
        chk("R4 data", rx_data, 8'h55);
        ack();

        // R5 break
        send(8'h00, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 break flags", {rx_ready, brk_det, frm_err}, 3'b111);
        chk("R5 break data", rx_data, 8'h00);
        ack();

        // R1 false start: low for 4 ticks only
        rx_line = 1'b0;
        repeat (4 * TICK_DIV) @(negedge clk);
        rx_line = 1'b1;
        repeat (14 * BIT_CLKS) @(negedge clk);
        chk("R1 glitch gives no char", rx_ready, 0);
        send(8'hC3, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R1 frame after glitch", {rx_ready, rx_data}, {1'b1, 8'hC3});
        ack();

        // R7 overrun keeps the first character
        send(8'h12, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        send(8'h34, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R7 overrun flag", {rx_ready, ovr_err}, 2'b11);
        chk("R7 old data kept", rx_data, 8'h12);
        ack();
        chk("R6 ack clears overrun", {rx_ready, ovr_err}, 2'b00);

        // R9 search
        search_en = 1'b1;
        search_char = 8'h3C;
        send(8'h3C, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 hit", {rx_ready, char_hit}, 2'b11);
        ack();
        send(8'h3D, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 miss", {rx_ready, char_hit}, 2'b10);
        ack();
        search_en = 1'b0;
        send(8'h3C, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R9 disabled", {rx_ready, char_hit}, 2'b10);
        ack();

        // R10 loopback, line held low
        rx_line = 1'b0;
        loop_en = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        chk("R10 line ignored", rx_ready, 0);
        send(8'h96, 8, 0, 1'b0, 1'b1, 1'b0, 1'b1);
        chk("R10 loop data", {rx_ready, rx_data, frm_err}, {1'b1, 8'h96, 1'b0});
        ack();
        rx_line = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
        loop_en = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);

        // R8 wake-up
        wake_en = 1'b1;
        own_addr = 8'h42;
        send(8'h11, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 asleep drops data", {rx_ready, addr_match}, 2'b00);
        send(8'h40, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 wrong address", {rx_ready, addr_match}, 2'b00);
        send(8'h42, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 match wakes, address hidden", {rx_ready, addr_match}, 2'b01);
        par_mode = 2'd1;
        send(8'h77, 8, 1, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 awake delivers", {rx_ready, rx_data, par_err}, {1'b1, 8'h77, 1'b0});
        ack();
        par_mode = 2'd0;
        send(8'h43, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 other address sleeps", {rx_ready, addr_match}, 2'b00);
        send(8'h12, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 dropped again", rx_ready, 0);
        send(8'h00, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R5 break while asleep", {rx_ready, brk_det, frm_err}, 3'b111);
        ack();
        send(8'h42, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8 rewake", addr_match, 1);
        wake_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 mode off clears match", addr_match, 0);
        send(8'hE7, 8, 0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R8 no flag bit when off", {rx_ready, rx_data, frm_err}, {1'b1, 8'hE7, 1'b0});
        ack();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule